// File: doc/BRIEF.md
# ADC Calibration and Conversion Sequencer

This block is the control state machine placed in front of a successive-approximation converter core. It watches the start-of-sample request and the control-register write strobe, and it decides what each request means. After power-on the first request starts a settling wait. The first request after that wait starts an automatic full self-calibration. Every request after that starts a conversion. Software can also start a calibration of one of four kinds by writing the control register with the start-calibration bit set.

The block drives a busy flag, a one-cycle conversion-start pulse toward the core, and a calibration-active flag with the kind being run and the step in progress (DAC trim, gain trim, offset trim). The trim steps, the analog conversion and the host bus are outside the block. Every duration is a parameter in clock cycles. A full calibration runs DAC, gain and offset steps, and its length is the sum of the three.

Top module: `adc_cal_sequencer`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `busy`, `conv_go` and `cal_active` are 0 and `cal_step` is 2'b00.
- R2: After reset, the first accepted `sample_req` starts the settling wait. `busy` is 1 from the next clock edge for exactly SETTLE_CYC cycles. `cal_active` stays 0 and no `conv_go` is issued.
- R3: A `sample_req` that arrives while `busy` is 1 is dropped. It issues no `conv_go` and does not lengthen the busy period.
- R4: If no control write has occurred, the first `sample_req` after the settling wait starts an automatic full calibration. `cal_kind` reads 2'b00, and `busy` is high for DAC_CYC+GAIN_CYC+OFS_CYC cycles.
- R5: Once the settling wait and any automatic calibration have finished, each `sample_req` seen while `busy` is 0 gives `conv_go`=1 in the following cycle only, and `busy` stays 0.
- R6: Any `cfg_wr` that occurs before the automatic calibration starts cancels that calibration. This includes a write before the first request and a write during the settling wait. The settling wait still runs its full length, and the next request starts a conversion.
- R7: A `cfg_wr` that occurs during the automatic calibration does not shorten or end it.
- R8: A `cfg_wr` with `cfg_cal_go`=1 while `busy` is 0 starts a calibration of kind `cfg_cal_kind`, with `busy` and `cal_active` rising at the next edge. The kinds are 2'b00 full (DAC_CYC+GAIN_CYC+OFS_CYC cycles), 2'b01 gain then offset (GAIN_CYC+OFS_CYC), 2'b10 offset only (OFS_CYC) and 2'b11 gain only (GAIN_CYC).
- R9: `cal_step` encodes the step as 2'b01 DAC, 2'b10 gain and 2'b11 offset, and reads 2'b00 when no calibration is running. A full calibration walks DAC, gain, offset. Gain-then-offset walks gain, offset.
- R10: A calibration write that arrives while `busy` is 1 is ignored. `cal_kind` and the busy length do not change.
- R11: When `cfg_wr` with `cfg_cal_go`=1 and `sample_req` arrive in the same idle cycle, the calibration starts and no `conv_go` is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| sample_req | input | 1 | Start-of-sample request, one cycle per request |
| cfg_wr | input | 1 | Control-register write strobe |
| cfg_cal_go | input | 1 | Start-calibration bit of the written word |
| cfg_cal_kind | input | 2 | Calibration kind of the written word |
| busy | output | 1 | High during the settling wait and during calibrations |
| conv_go | output | 1 | One-cycle conversion start toward the core |
| cal_active | output | 1 | High while a calibration runs |
| cal_kind | output | 2 | Kind of the current or last calibration |
| cal_step | output | 2 | Step of the running calibration, 2'b00 when none |

## Verification
The request path is tested with three patterns: the first request after reset, the request that follows the settling wait, and later requests. Each pattern must give a different outcome: settling wait, automatic calibration or conversion. The control-write patterns are a write before the first request, a write during the settling wait and a write during the automatic calibration. These show which writes cancel the automatic calibration and which do not abort it. Each of the four software calibration kinds is measured for busy length and step order, which separates full from gain-then-offset and offset from gain. Other tests send requests and writes while busy, and a write and a request in the same cycle, to show which input is dropped.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        CAL_FULL     = 2'b00,
        CAL_GAIN_OFS = 2'b01,
        CAL_OFS      = 2'b10,
        CAL_GAIN     = 2'b11
    } cal_kind_e;

    typedef enum logic [1:0] {
        STEP_NONE = 2'b00,
        STEP_DAC  = 2'b01,
        STEP_GAIN = 2'b10,
        STEP_OFS  = 2'b11
    } cal_step_e;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'b00,
        SEQ_SETTLE = 2'b01,
        SEQ_CAL    = 2'b10
    } seq_mode_e;

endpackage

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
    parameter int CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/adc_seq_step_plan.sv
module adc_seq_step_plan
    import adc_seq_pkg::*;
#(
    parameter int CNT_W    = 17,
    parameter int DAC_CYC  = 97240,
    parameter int GAIN_CYC = 13880,
    parameter int OFS_CYC  = 13880
) (
    input  cal_kind_e        req_kind,
    input  cal_kind_e        run_kind,
    input  cal_step_e        run_step,
    output cal_step_e        first_step,
    output logic [CNT_W-1:0] first_len_m1,
    output cal_step_e        next_step,
    output logic [CNT_W-1:0] next_len_m1
);

    localparam logic [CNT_W-1:0] DAC_M1  = CNT_W'(DAC_CYC - 1);
    localparam logic [CNT_W-1:0] GAIN_M1 = CNT_W'(GAIN_CYC - 1);
    localparam logic [CNT_W-1:0] OFS_M1  = CNT_W'(OFS_CYC - 1);

    function automatic logic [CNT_W-1:0] step_len(input cal_step_e s);
        case (s)
            STEP_DAC:  return DAC_M1;
            STEP_GAIN: return GAIN_M1;
            STEP_OFS:  return OFS_M1;
            default:   return '0;
        endcase
    endfunction

    always_comb begin
        case (req_kind)
            CAL_FULL:     first_step = STEP_DAC;
            CAL_GAIN_OFS: first_step = STEP_GAIN;
            CAL_OFS:      first_step = STEP_OFS;
            default:      first_step = STEP_GAIN;
        endcase
        first_len_m1 = step_len(first_step);
    end

    always_comb begin
        case (run_step)
            STEP_DAC:  next_step = STEP_GAIN;
            STEP_GAIN: next_step = (run_kind == CAL_GAIN) ? STEP_NONE : STEP_OFS;
            default:   next_step = STEP_NONE;
        endcase
        next_len_m1 = step_len(next_step);
    end

endmodule

// File: rtl/adc_cal_sequencer.sv
module adc_cal_sequencer
    import adc_seq_pkg::*;
#(
    parameter int SETTLE_CYC = 128000,
    parameter int DAC_CYC    = 97240,
    parameter int GAIN_CYC   = 13880,
    parameter int OFS_CYC    = 13880
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sample_req,
    input  logic       cfg_wr,
    input  logic       cfg_cal_go,
    input  logic [1:0] cfg_cal_kind,
    output logic       busy,
    output logic       conv_go,
    output logic       cal_active,
    output logic [1:0] cal_kind,
    output logic [1:0] cal_step
);

    localparam int MAX_A   = (SETTLE_CYC > DAC_CYC) ? SETTLE_CYC : DAC_CYC;
    localparam int MAX_B   = (GAIN_CYC > OFS_CYC) ? GAIN_CYC : OFS_CYC;
    localparam int MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] SETTLE_M1 = CNT_W'(SETTLE_CYC - 1);

    typedef struct packed {
        seq_mode_e mode;
        logic      settled;
        logic      auto_pend;
        cal_kind_e kind;
        cal_step_e step;
        logic      conv_go;
    } seq_state_t;

    seq_state_t st_d, st_q;

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;

    logic             wr_cal;
    cal_kind_e        plan_kind;
    cal_step_e        first_step, next_step;
    logic [CNT_W-1:0] first_len_m1, next_len_m1;

    assign wr_cal    = cfg_wr && cfg_cal_go;
    assign plan_kind = wr_cal ? cal_kind_e'(cfg_cal_kind) : CAL_FULL;

    adc_seq_step_plan #(
        .CNT_W   (CNT_W),
        .DAC_CYC (DAC_CYC),
        .GAIN_CYC(GAIN_CYC),
        .OFS_CYC (OFS_CYC)
    ) u_plan (
        .req_kind    (plan_kind),
        .run_kind    (st_q.kind),
        .run_step    (st_q.step),
        .first_step  (first_step),
        .first_len_m1(first_len_m1),
        .next_step   (next_step),
        .next_len_m1 (next_len_m1)
    );

    adc_seq_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .expired (tmr_expired)
    );

    always_comb begin
        st_d         = st_q;
        st_d.conv_go = 1'b0;
        tmr_load     = 1'b0;
        tmr_val      = '0;

        // Any register write retires a pending automatic calibration.
        if (cfg_wr) begin
            st_d.auto_pend = 1'b0;
        end

        case (st_q.mode)
            SEQ_IDLE: begin
                if (wr_cal) begin
                    st_d.mode = SEQ_CAL;
                    st_d.kind = plan_kind;
                    st_d.step = first_step;
                    tmr_load  = 1'b1;
                    tmr_val   = first_len_m1;
                end else if (sample_req) begin
                    if (!st_q.settled) begin
                        st_d.mode = SEQ_SETTLE;
                        tmr_load  = 1'b1;
                        tmr_val   = SETTLE_M1;
                    end else if (st_q.auto_pend && !cfg_wr) begin
                        st_d.mode      = SEQ_CAL;
                        st_d.kind      = CAL_FULL;
                        st_d.step      = first_step;
                        st_d.auto_pend = 1'b0;
                        tmr_load       = 1'b1;
                        tmr_val        = first_len_m1;
                    end else begin
                        st_d.conv_go = 1'b1;
                    end
                end
            end
            SEQ_SETTLE: begin
                if (tmr_expired) begin
                    st_d.mode    = SEQ_IDLE;
                    st_d.settled = 1'b1;
                end
            end
            SEQ_CAL: begin
                if (tmr_expired) begin
                    if (next_step == STEP_NONE) begin
                        st_d.mode = SEQ_IDLE;
                        st_d.step = STEP_NONE;
                    end else begin
                        st_d.step = next_step;
                        tmr_load  = 1'b1;
                        tmr_val   = next_len_m1;
                    end
                end
            end
            default: begin
                st_d.mode = SEQ_IDLE;
                st_d.step = STEP_NONE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode      <= SEQ_IDLE;
            st_q.settled   <= 1'b0;
            st_q.auto_pend <= 1'b1;
            st_q.kind      <= CAL_FULL;
            st_q.step      <= STEP_NONE;
            st_q.conv_go   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy       = (st_q.mode != SEQ_IDLE);
    assign conv_go    = st_q.conv_go;
    assign cal_active = (st_q.mode == SEQ_CAL);
    assign cal_kind   = st_q.kind;
    assign cal_step   = st_q.step;

endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       sample_req,
    input logic       cfg_wr,
    input logic       cfg_cal_go,
    input logic [1:0] cal_kind,
    input logic       busy,
    input logic       conv_go,
    input logic       cal_active,
    input logic [1:0] cal_step
);

    assert_req_dropped_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && sample_req) |=> !conv_go);

    assert_conv_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        conv_go |-> !busy);

    assert_conv_from_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        conv_go |-> $past(sample_req));

    assert_cal_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cfg_wr && cfg_cal_go) |=> cal_active);

    assert_active_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cal_active |-> busy);

    assert_step_present_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cal_active |-> (cal_step != 2'b00));

    assert_step_absent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cal_active |-> (cal_step == 2'b00));

    assert_dac_next_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_step == 2'b01) |=> (cal_step == 2'b01 || cal_step == 2'b10));

    assert_ofs_next_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_step == 2'b11) |=> (cal_step == 2'b11 || cal_step == 2'b00));

    assert_gain_next_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_step == 2'b10) |=> (cal_step != 2'b01));

    assert_kind_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cfg_wr) |=> $stable(cal_kind));

endmodule

bind adc_cal_sequencer adc_seq_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample_req(sample_req),
    .cfg_wr    (cfg_wr),
    .cfg_cal_go(cfg_cal_go),
    .cal_kind  (cal_kind),
    .busy      (busy),
    .conv_go   (conv_go),
    .cal_active(cal_active),
    .cal_step  (cal_step)
);

// File: tb/adc_cal_sequencer_test.sv
`timescale 1ns/1ps
module adc_cal_sequencer_test;

    localparam int SETTLE = 20;
    localparam int DAC    = 12;
    localparam int GAIN   = 5;
    localparam int OFS    = 4;

    // {kind, expected busy cycles, expected step sequence}
    localparam logic [15:0] VEC [4] = '{
        {2'b00, 8'(DAC + GAIN + OFS), 6'b011011},
        {2'b01, 8'(GAIN + OFS),       6'b001011},
        {2'b10, 8'(OFS),              6'b000011},
        {2'b11, 8'(GAIN),             6'b000010}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sample_req = 1'b0;
    logic       cfg_wr = 1'b0;
    logic       cfg_cal_go = 1'b0;
    logic [1:0] cfg_cal_kind = 2'b00;
    logic       busy, conv_go, cal_active;
    logic [1:0] cal_kind, cal_step;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #2 clk = ~clk;

    adc_cal_sequencer #(
        .SETTLE_CYC(SETTLE),
        .DAC_CYC   (DAC),
        .GAIN_CYC  (GAIN),
        .OFS_CYC   (OFS)
    ) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_req  (sample_req),
        .cfg_wr      (cfg_wr),
        .cfg_cal_go  (cfg_cal_go),
        .cfg_cal_kind(cfg_cal_kind),
        .busy        (busy),
        .conv_go     (conv_go),
        .cal_active  (cal_active),
        .cal_kind    (cal_kind),
        .cal_step    (cal_step)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        sample_req = 1'b0;
        cfg_wr = 1'b0;
        cfg_cal_go = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Drive inputs for one cycle; returns at the negedge after the sampling edge.
    task automatic kick(input logic p, input logic w, input logic go, input logic [1:0] k);
        sample_req = p;
        cfg_wr = w;
        cfg_cal_go = go;
        cfg_cal_kind = k;
        @(negedge clk);
        sample_req = 1'b0;
        cfg_wr = 1'b0;
        cfg_cal_go = 1'b0;
    endtask

    // inj_kind: 0 none, 1 request, 2 write without go, 3 write with go
    task automatic run_busy(input int inj_at, input int inj_kind, input logic [1:0] inj_cal,
                            output int n, output logic [5:0] seq,
                            output logic saw_conv, output logic saw_act);
        logic [1:0] last;
        n = 0;
        seq = '0;
        last = 2'b00;
        saw_conv = 1'b0;
        saw_act = 1'b0;
        while (busy && n < 1000) begin
            if (cal_step != last) begin
                seq = {seq[3:0], cal_step};
                last = cal_step;
            end
            if (conv_go) saw_conv = 1'b1;
            if (cal_active) saw_act = 1'b1;
            sample_req = 1'b0;
            cfg_wr = 1'b0;
            cfg_cal_go = 1'b0;
            if (n == inj_at) begin
                case (inj_kind)
                    1: sample_req = 1'b1;
                    2: cfg_wr = 1'b1;
                    3: begin cfg_wr = 1'b1; cfg_cal_go = 1'b1; cfg_cal_kind = inj_cal; end
                    default: ;
                endcase
            end
            n++;
            @(negedge clk);
        end
        sample_req = 1'b0;
        cfg_wr = 1'b0;
        cfg_cal_go = 1'b0;
        if (conv_go) saw_conv = 1'b1;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        int n;
        logic [5:0] seq;
        logic sc, sa;

        // R1: reset state
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(busy == 1'b0, "R1", "busy in reset", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0, "R1", "busy", busy, 0);
        check(conv_go == 1'b0, "R1", "conv_go", conv_go, 0);
        check(cal_active == 1'b0, "R1", "cal_active", cal_active, 0);
        check(cal_step == 2'b00, "R1", "cal_step", cal_step, 0);

        // R2/R3: settling wait, request injected mid-way
        kick(1'b1, 1'b0, 1'b0, 2'b00);
        check(busy == 1'b1, "R2", "busy after first request", busy, 1);
        run_busy(3, 1, 2'b00, n, seq, sc, sa);
        check(n == SETTLE, "R2", "settle length", n, SETTLE);
        check(sa == 1'b0, "R2", "cal_active during settle", sa, 0);
        check(sc == 1'b0, "R3", "conv_go from dropped request", sc, 0);

        // R4/R7/R9: automatic full calibration, calibration write mid-way
        kick(1'b1, 1'b0, 1'b0, 2'b00);
        check(cal_active == 1'b1, "R4", "auto cal active", cal_active, 1);
        check(cal_kind == 2'b00, "R4", "auto cal kind", cal_kind, 0);
        run_busy(5, 3, 2'b10, n, seq, sc, sa);
        check(n == DAC + GAIN + OFS, "R7", "auto cal length with write", n, DAC + GAIN + OFS);
        check(seq == 6'b011011, "R9", "auto cal steps", seq, 6'b011011);
        check(cal_kind == 2'b00, "R10", "kind after ignored write", cal_kind, 0);
        check(sc == 1'b0, "R4", "no conv during auto cal", sc, 0);

        // R5: conversions
        kick(1'b1, 1'b0, 1'b0, 2'b00);
        check(conv_go == 1'b1, "R5", "conv_go after request", conv_go, 1);
        check(busy == 1'b0, "R5", "busy during conversion start", busy, 0);
        @(negedge clk);
        check(conv_go == 1'b0, "R5", "conv_go width", conv_go, 0);
        kick(1'b1, 1'b0, 1'b0, 2'b00);
        check(conv_go == 1'b1 && cal_active == 1'b0, "R5", "second conversion", conv_go, 1);

        // R8/R9/R10: software calibrations from the vector table
        for (int i = 0; i < 4; i++) begin
            logic [1:0] k;
            int len;
            logic [5:0] xs;
            k = VEC[i][15:14];
            len = int'(VEC[i][13:6]);
            xs = VEC[i][5:0];
            kick(1'b0, 1'b1, 1'b1, k);
            check(cal_active == 1'b1, "R8", "cal_active after write", cal_active, 1);
            check(cal_kind == k, "R8", "cal_kind", cal_kind, k);
            run_busy(1, 3, ~k, n, seq, sc, sa);
            check(n == len, "R8", "calibration length", n, len);
            check(seq == xs, "R9", "step sequence", seq, xs);
            check(cal_kind == k, "R10", "kind kept after ignored write", cal_kind, k);
        end

        // R11: write and request together
        kick(1'b1, 1'b1, 1'b1, 2'b10);
        check(conv_go == 1'b0, "R11", "conv_go on collision", conv_go, 0);
        check(cal_active == 1'b1, "R11", "cal started on collision", cal_active, 1);
        run_busy(-1, 0, 2'b00, n, seq, sc, sa);
        check(n == OFS, "R11", "collision cal length", n, OFS);

        // R6: write during the settling wait
        do_reset();
        kick(1'b1, 1'b0, 1'b0, 2'b00);
        run_busy(4, 2, 2'b00, n, seq, sc, sa);
        check(n == SETTLE, "R6", "settle length with write", n, SETTLE);
        kick(1'b1, 1'b0, 1'b0, 2'b00);
        check(conv_go == 1'b1, "R6", "conversion instead of auto cal", conv_go, 1);
        check(busy == 1'b0, "R6", "busy after cancelled auto cal", busy, 0);

        // R6: write before the first request
        do_reset();
        kick(1'b0, 1'b1, 1'b0, 2'b00);
        check(busy == 1'b0, "R6", "busy after plain write", busy, 0);
        kick(1'b1, 1'b0, 1'b0, 2'b00);
        run_busy(-1, 0, 2'b00, n, seq, sc, sa);
        check(n == SETTLE, "R6", "settle after early write", n, SETTLE);
        kick(1'b1, 1'b0, 1'b0, 2'b00);
        check(conv_go == 1'b1 && cal_active == 1'b0, "R6", "conversion after early write", conv_go, 1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule